// File: doc/BRIEF.md
# Pointer-addressed port bit manipulator

This block lets a small controller core set, clear or test a single output port pin. The pin is chosen at run time by a pointer register, not by a bit number held in the instruction. The core first loads the pointer with a 4-bit immediate. It then issues a bit command, and the block works out which latch the pointer names and acts on that latch alone.

Sixteen latches are kept, grouped as four ports of four bits: port 4, port 5, port 6 and port 7. A pointer value `p` selects bit `p mod 4` of port `4 + p/4`. On the flattened output this is simply bit `p` of `port_q`: port 4 occupies `port_q[3:0]`, port 5 occupies `port_q[7:4]`, and so on. A test command copies the selected latch into a one-bit flag that the core can read.

Top module: `ptr_bit_ctl`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block is reset. After that edge, all `port_q` bits are 1, the pointer is 0 and `tst_flag` is 0.
- R2: When `ptr_ld` is 1 at a rising edge, the pointer takes `ptr_val`. Commands issued in later cycles use this new value.
- R3: Pointer value p selects `port_q[p]`. That latch is bit p mod 4 of port 4 + p/4, and port 4 occupies `port_q[3:0]`.
- R4: Opcode 01 with `cmd_vld` = 1 makes the selected latch 1 after the rising edge.
- R5: Opcode 10 with `cmd_vld` = 1 makes the selected latch 0 after the rising edge.
- R6: A set or clear leaves every other latch unchanged.
- R7: Opcode 11 with `cmd_vld` = 1 loads `tst_flag` with the selected latch's value before the edge, and the flag is visible one cycle after the strobe. The flag holds its value until the next test.
- R8: Opcode 00, or any opcode with `cmd_vld` = 0, changes no latch and leaves the flag unchanged.
- R9: If `ptr_ld` and a command fall in the same cycle, the command acts on the pointer value held before that load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ptr_ld | input | 1 | Pointer load strobe |
| ptr_val | input | 4 | Immediate value for the pointer |
| cmd_vld | input | 1 | Bit command strobe |
| cmd_op | input | 2 | 00 none, 01 set, 10 clear, 11 test |
| port_q | output | 16 | Port latches, bit p is the latch selected by pointer p |
| tst_flag | output | 1 | Result of the last test |

## Verification
Two functions can fall in the same cycle: a pointer load and a bit command. When they coincide, the command must act on the old pointer value, and the new value must take effect only from the following cycle. The bench forces this case with directed steps. In those steps the old and new pointers name latches whose states differ, so a design that uses the wrong pointer changes a different latch, or reports a different flag. The bench detects either error. Random traffic then mixes loads and commands freely. Every cycle, the latches and the flag are compared against a behavioural model, which updates its pointer only after it has served the command.

// File: rtl/pbm_pkg.sv
// Package: shared opcode encoding for the pointer-addressed bit manipulator.
// Assumes a 2-bit command opcode field.
package pbm_pkg;
    typedef enum logic [1:0] {
        OP_NOP = 2'b00,
        OP_SET = 2'b01,
        OP_CLR = 2'b10,
        OP_TST = 2'b11
    } bitop_e;
endpackage

// File: rtl/pbm_ptr_reg.sv
// Pointer register: holds the bit pointer that later commands use.
// Assumes the load strobe is a single-cycle pulse; reset is synchronous, active-low.
module pbm_ptr_reg #(
    parameter int PTR_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld,
    input  logic [PTR_W-1:0] val,
    output logic [PTR_W-1:0] ptr
);
    // Capture a new pointer on load, and clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)  ptr <= '0;
        else if (ld) ptr <= val;
    end

    // R2
    ptr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld |=> ptr == $past(val));
endmodule

// File: rtl/pbm_sel_decode.sv
// Select decoder: turns the pointer into a one-hot select over all latches.
// Assumes NBITS <= 2**PTR_W; pointer values that name no latch select nothing.
module pbm_sel_decode #(
    parameter int PTR_W = 4,
    parameter int NBITS = 16
) (
    input  logic [PTR_W-1:0] ptr,
    output logic [NBITS-1:0] sel
);
    for (genvar g = 0; g < NBITS; g++) begin : g_sel
        assign sel[g] = (ptr == PTR_W'(g));
    end

    // R3
    sel_onehot_chk: assert property (@(ptr) $countones(sel) <= 1);
endmodule

// File: rtl/pbm_latch_bank.sv
// Latch bank: one register per port pin; set or clear acts only on the selected pin.
// Assumes sel is one-hot or zero; reset is synchronous, active-low, and drives all pins high.
module pbm_latch_bank #(
    parameter int NBITS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_set,
    input  logic             do_clr,
    input  logic [NBITS-1:0] sel,
    output logic [NBITS-1:0] q
);
    for (genvar g = 0; g < NBITS; g++) begin : g_bit
        // Update one pin: force high on reset, then apply set or clear when this pin is selected.
        always_ff @(posedge clk) begin
            if (!rst_n)                q[g] <= 1'b1;
            else if (sel[g] && do_set) q[g] <= 1'b1;
            else if (sel[g] && do_clr) q[g] <= 1'b0;
        end

        // R4
        set_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (do_set && sel[g]) |=> q[g]);
        // R5
        clr_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (do_clr && sel[g]) |=> !q[g]);
        // R6
        other_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !((do_set || do_clr) && sel[g]) |=> $stable(q[g]));
    end
endmodule

// File: rtl/pbm_test_unit.sv
// Test unit: samples the selected latch into a flag on a test command.
// Assumes the latch vector is read before the same-edge update; reset is synchronous, active-low.
module pbm_test_unit #(
    parameter int PTR_W = 4,
    parameter int NBITS = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_tst,
    input  logic [PTR_W-1:0] ptr,
    input  logic [NBITS-1:0] q,
    output logic             flag
);
    logic picked;

    // Pick the latch that the pointer names.
    always_comb begin
        picked = 1'b0;
        for (int i = 0; i < NBITS; i++)
            if (ptr == PTR_W'(i)) picked = q[i];
    end

    // Load the flag on a test, and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (do_tst) flag <= picked;
    end

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !do_tst |=> $stable(flag));
endmodule

// File: rtl/ptr_bit_ctl.sv
// Top: pointer-addressed set/clear/test of port pins.
// Assumes commands and pointer loads are single-cycle strobes. A command in the same cycle
// as a load uses the pointer held before that load. Reset is synchronous, active-low.
module ptr_bit_ctl
    import pbm_pkg::*;
#(
    parameter int PORT_W    = 4,
    parameter int NUM_PORTS = 4,
    localparam int NBITS    = PORT_W * NUM_PORTS,
    localparam int PTR_W    = $clog2(NBITS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ptr_ld,
    input  logic [PTR_W-1:0] ptr_val,
    input  logic             cmd_vld,
    input  logic [1:0]       cmd_op,
    output logic [NBITS-1:0] port_q,
    output logic             tst_flag
);
    logic [PTR_W-1:0] ptr;
    logic [NBITS-1:0] sel;
    logic             do_set, do_clr, do_tst;
    bitop_e           op;

    assign op     = bitop_e'(cmd_op);
    assign do_set = cmd_vld && (op == OP_SET);
    assign do_clr = cmd_vld && (op == OP_CLR);
    assign do_tst = cmd_vld && (op == OP_TST);

    pbm_ptr_reg #(.PTR_W(PTR_W)) u_ptr (
        .clk(clk), .rst_n(rst_n), .ld(ptr_ld), .val(ptr_val), .ptr(ptr));

    pbm_sel_decode #(.PTR_W(PTR_W), .NBITS(NBITS)) u_dec (
        .ptr(ptr), .sel(sel));

    pbm_latch_bank #(.NBITS(NBITS)) u_bank (
        .clk(clk), .rst_n(rst_n), .do_set(do_set), .do_clr(do_clr),
        .sel(sel), .q(port_q));

    pbm_test_unit #(.PTR_W(PTR_W), .NBITS(NBITS)) u_tst (
        .clk(clk), .rst_n(rst_n), .do_tst(do_tst), .ptr(ptr),
        .q(port_q), .flag(tst_flag));

    // R7
    tst_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_tst |=> tst_flag == $past(port_q[ptr]));
    // R8
    nop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(do_set || do_clr) |=> $stable(port_q));
endmodule

// File: tb/tb_ptr_bit_ctl.sv
// Bench: behavioural model of latches, pointer and flag, compared with the design on every clock.
module tb_ptr_bit_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ptr_ld = 1'b0;
    logic [3:0]  ptr_val = '0;
    logic        cmd_vld = 1'b0;
    logic [1:0]  cmd_op = '0;
    logic [15:0] port_q;
    logic        tst_flag;

    int checks = 0;
    int errors = 0;
    bit m_pin [16];
    int m_ptr = 0;
    bit m_flag = 1'b0;

    always #4 clk = ~clk;

    ptr_bit_ctl dut (.clk(clk), .rst_n(rst_n), .ptr_ld(ptr_ld), .ptr_val(ptr_val),
        .cmd_vld(cmd_vld), .cmd_op(cmd_op), .port_q(port_q), .tst_flag(tst_flag));

    // Reference model: the command uses the current pointer, then the load takes effect.
    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_pin[i]) m_pin[i] = 1'b1;
            m_ptr = 0;
            m_flag = 1'b0;
        end else begin
            if (cmd_vld && cmd_op == 2'b01) m_pin[m_ptr] = 1'b1;
            else if (cmd_vld && cmd_op == 2'b10) m_pin[m_ptr] = 1'b0;
            else if (cmd_vld && cmd_op == 2'b11) m_flag = m_pin[m_ptr];
            if (ptr_ld) m_ptr = int'(ptr_val);
        end
    end

    function automatic logic [15:0] model_vec();
        logic [15:0] v;
        for (int i = 0; i < 16; i++) v[i] = m_pin[i];
        return v;
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Apply one cycle of stimulus after a falling edge, then compare at the next falling edge.
    task automatic step(input bit ld, input int val, input bit vld, input int op);
        ptr_ld = ld; ptr_val = 4'(val); cmd_vld = vld; cmd_op = 2'(op);
        @(negedge clk);
        chk("R6 latches vs model", port_q, model_vec());
        chk("R7 flag vs model", {15'd0, tst_flag}, {15'd0, m_flag});
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset latches", port_q, 16'hFFFF);
        chk("R1 reset flag", {15'd0, tst_flag}, 16'd0);
        // R1: the pointer resets to 0, so a clear acts on port 4 bit 0
        step(0, 0, 1, 2);
        chk("R1 pointer zero after reset", port_q, 16'hFFFE);
        // R2, R3: load pointer 9, which is port 6 bit 1, then clear it
        step(1, 9, 0, 0);
        step(0, 0, 1, 2);
        chk("R3 pointer 9 clears port6 bit1", port_q, 16'hFDFE);
        // R4: set it back
        step(0, 0, 1, 1);
        chk("R4 set", port_q, 16'hFFFE);
        // R5, R6: clear pointer 15
        step(1, 15, 0, 0);
        step(0, 0, 1, 2);
        chk("R5 clear port7 bit3", port_q, 16'h7FFE);
        // R7: test the cleared bit, then test a set bit
        step(0, 0, 1, 3);
        chk("R7 test of 0", {15'd0, tst_flag}, 16'd0);
        step(1, 4, 0, 0);
        step(0, 0, 1, 3);
        chk("R7 test of 1", {15'd0, tst_flag}, 16'd1);
        // R8: no-op opcode, and a strobe with cmd_vld low
        step(0, 0, 1, 0);
        step(0, 0, 0, 2);
        chk("R8 ignored commands latches", port_q, 16'h7FFE);
        chk("R8 ignored commands flag", {15'd0, tst_flag}, 16'd1);
        // R9: the pointer is 4; load 15 in the same cycle as a clear, so bit 4 must clear
        step(1, 15, 1, 2);
        chk("R9 old pointer used by clear", port_q, 16'h7FEE);
        // R9: a set in the next cycle uses 15
        step(0, 0, 1, 1);
        chk("R9 new pointer next cycle", port_q, 16'hFFEE);
        // R9: pointer 15 (bit is 1); load 0 (bit is 0) together with a test, so the flag must be 1
        step(1, 0, 1, 3);
        chk("R9 old pointer used by test", {15'd0, tst_flag}, 16'd1);
        for (int n = 0; n < 400; n++)
            step(1'($urandom_range(0, 1)), $urandom_range(0, 15),
                 1'($urandom_range(0, 1)), $urandom_range(0, 3));
        // R1: reset in mid-run
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R1 reset again latches", port_q, 16'hFFFF);
        chk("R1 reset again flag", {15'd0, tst_flag}, 16'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule